// File: doc/BRIEF.md
# I2C Register Target with Auto-Incrementing Pointer

This block is an I2C target with a fixed 7-bit device address. It gives a master access to a small array of byte-wide registers. The system clock samples SCL and SDA through synchronizers and detects START and STOP conditions from them. Bytes are shifted MSB first. The target answers with an acknowledge on the ninth clock after three kinds of byte: an address byte that matches, the pointer byte, and each written data byte. It pulls SDA low through an output-enable pin, so the line is open-drain.

To write, the master sends the address byte with the write bit, then a pointer byte, then one or more data bytes. To read, the master sets the pointer the same way, issues a repeated START, sends the address byte with the read bit, and clocks data out for as long as it acknowledges. After every byte that is written or read, the pointer steps by one, and past the last register it wraps to register 0. The register array sits outside the block. The block drives a one-cycle write strobe with an address and data. On the read side it presents an address and takes the data back, and it accepts a read that is either combinational or has one cycle of latency.

Top module: `i2c_regfile_target`

## Requirements
- R1: After a synchronous reset the target leaves SDA released (`sda_oe`=0), holds `reg_we` low and sets `reg_raddr` to 0.
- R2: Only an address byte whose upper seven bits are 1000100 is acknowledged. Its LSB selects the direction: 0 is write, 1 is read. After any other address the target acknowledges nothing and writes nothing until the next START.
- R3: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Bus activity that is not preceded by a START is ignored.
- R4: A byte write sends the address byte with the write bit, a pointer byte and a data byte. The target acknowledges all three and then gives exactly one single-cycle `reg_we` pulse, carrying the pointer value and the data byte.
- R5: In a burst write, each data byte goes to the current pointer and the pointer then steps by one. After register NUM_REGS-1 the next byte goes to register 0.
- R6: For a read, the master sets the pointer with a write transfer and then issues a repeated START with address byte 0x89. The target then shifts out the selected register, MSB first.
- R7: While the master acknowledges, the target keeps sending the next register, with the same wrap as R5. The pointer also advances past the last byte sent. A master NACK makes the target release SDA and go idle.
- R8: If a STOP arrives before a data byte and its ACK clock are complete, the target performs no write and the register contents stay unchanged.
- R9: The target changes `sda_oe` only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain) |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_waddr | output | PTR_W | Register write address |
| reg_wdata | output | 8 | Register write data |
| reg_raddr | output | PTR_W | Register read address (current pointer) |
| reg_rdata | input | 8 | Register read data; zero or one cycle latency |

## Verification
A corrupted pointer shows up on the next write strobe as the wrong `reg_waddr`, or as the wrong byte in the following read. Either is visible within one byte time. If the bit counter slips, the ACK lands on the wrong SCL pulse, and the master sees a missing acknowledge on the ninth clock of the affected byte. A state that fails to leave idle, or one that fails to return to it, appears as a missing ACK, or as SDA being driven after a NACK or a STOP. A stray strobe after a truncated transfer changes a register that the bench reads back immediately afterwards.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_REG,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK
  } tgt_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;

  // Idle bus level is high on both lines.
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // R3: line conditions seen while SCL is held high
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_target_ctrl.sv
module i2c_target_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1000100,
  parameter int         PTR_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [BYTE_W-1:0] reg_rdata,
  output logic              sda_oe,
  output logic              reg_we,
  output logic [PTR_W-1:0]  reg_waddr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic [PTR_W-1:0]  reg_raddr
);
  localparam logic [3:0] LAST_BIT = 4'(BYTE_W);

  tgt_state_t        state;
  tgt_state_t        after_ack;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] wbuf;
  logic [3:0]        bitcnt;
  logic              do_write;
  logic              mack;
  logic [PTR_W-1:0]  ptr;

  assign reg_raddr = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      after_ack <= ST_IDLE;
      shreg     <= '0;
      wbuf      <= '0;
      bitcnt    <= '0;
      do_write  <= 1'b0;
      mack      <= 1'b0;
      ptr       <= '0;
      sda_oe    <= 1'b0;
      reg_we    <= 1'b0;
      reg_waddr <= '0;
      reg_wdata <= '0;
    end else begin
      reg_we <= 1'b0;
      if (stop_evt) begin
        // R8: a pending byte is dropped; no strobe is issued
        state    <= ST_IDLE;
        sda_oe   <= 1'b0;
        do_write <= 1'b0;
      end else if (start_evt) begin
        state    <= ST_ADDR;
        bitcnt   <= '0;
        sda_oe   <= 1'b0;
        do_write <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_REG, ST_WDATA: begin
            if (scl_rise) begin
              shreg  <= {shreg[BYTE_W-2:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == LAST_BIT) begin
              bitcnt <= '0;
              if (state == ST_ADDR) begin
                if (shreg[BYTE_W-1:1] == DEV_ADDR) begin
                  sda_oe    <= 1'b1;
                  state     <= ST_ACK;
                  after_ack <= shreg[0] ? ST_RDATA : ST_REG;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_REG) begin
                ptr       <= shreg[PTR_W-1:0];
                sda_oe    <= 1'b1;
                state     <= ST_ACK;
                after_ack <= ST_WDATA;
              end else begin
                wbuf      <= shreg;
                do_write  <= 1'b1;
                sda_oe    <= 1'b1;
                state     <= ST_ACK;
                after_ack <= ST_WDATA;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              sda_oe   <= 1'b0;
              bitcnt   <= '0;
              do_write <= 1'b0;
              state    <= after_ack;
              if (do_write) begin
                reg_we    <= 1'b1;
                reg_waddr <= ptr;
                reg_wdata <= wbuf;
                ptr       <= ptr + 1'b1;
              end
              if (after_ack == ST_RDATA) begin
                shreg  <= reg_rdata;
                sda_oe <= ~reg_rdata[BYTE_W-1];
              end
            end
          end
          ST_RDATA: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt == LAST_BIT) begin
                sda_oe <= 1'b0;
                state  <= ST_RACK;
                ptr    <= ptr + 1'b1;
              end else begin
                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                sda_oe <= ~shreg[BYTE_W-2];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                shreg  <= reg_rdata;
                sda_oe <= ~reg_rdata[BYTE_W-1];
                bitcnt <= '0;
                state  <= ST_RDATA;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R9: SDA moves only while SCL is low
  a_r9_sda_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_s);

  // R4: the write strobe lasts one cycle
  a_r4_single_strobe: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);

  // R5: the pointer has moved one past the written register
  a_r5_ptr_steps: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> (reg_raddr == reg_waddr + PTR_W'(1)));

  // R8: a STOP never produces a write on the following cycle
  a_r8_stop_no_write: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> !reg_we);

  // R2: SDA is never pulled while idle or while an address is shifted in
  a_r2_quiet_on_addr: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE || state == ST_ADDR) |-> !sda_oe);
endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target #(
  parameter logic [6:0] DEV_ADDR    = 7'b1000100,
  parameter int         PTR_W       = 3,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  output logic             reg_we,
  output logic [PTR_W-1:0] reg_waddr,
  output logic [7:0]       reg_wdata,
  output logic [PTR_W-1:0] reg_raddr,
  input  logic [7:0]       reg_rdata
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;

  i2c_line_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt)
  );

  i2c_target_ctrl #(
    .DEV_ADDR(DEV_ADDR),
    .PTR_W   (PTR_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt),
    .reg_rdata(reg_rdata),
    .sda_oe   (sda_oe),
    .reg_we   (reg_we),
    .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr)
  );
endmodule

// File: tb/i2c_regfile_target_bench.sv
module i2c_regfile_target_bench;
  localparam int PTR_W = 3;
  localparam int NREG  = 1 << PTR_W;
  localparam int Q     = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, reg_we;
  logic [PTR_W-1:0] reg_waddr, reg_raddr;
  logic [7:0] reg_wdata, reg_rdata;
  logic sda_line;

  int nchk = 0;
  int nerr = 0;
  int we_cnt = 0;
  int oe_cnt = 0;
  int bad_edge = 0;
  logic oe_prev = 1'b0;
  logic [7:0] regs [NREG];
  logic [7:0] expv [NREG];

  always #5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  i2c_regfile_target #(.PTR_W(PTR_W)) u_i2c_regfile_target (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata)
  );

  // Register array model with one cycle of read latency
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= 8'hA0 + 8'(i);
    end else if (reg_we) begin
      regs[reg_waddr] <= reg_wdata;
    end
    reg_rdata <= regs[reg_raddr];
  end

  always @(posedge clk) begin
    if (!rst) begin
      if (reg_we) we_cnt <= we_cnt + 1;
      if (sda_oe) oe_cnt <= oe_cnt + 1;
      if (sda_oe != oe_prev && scl_m) bad_edge <= bad_edge + 1;
    end
    oe_prev <= sda_oe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; waitq(1);
    scl_m = 1'b1; waitq(1);
    sda_m = 1'b0; waitq(1);
    scl_m = 1'b0; waitq(1);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; waitq(1);
    scl_m = 1'b1; waitq(1);
    sda_m = 1'b1; waitq(1);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; waitq(1);
      scl_m = 1'b1; waitq(2);
      scl_m = 1'b0; waitq(1);
    end
    sda_m = 1'b1; waitq(1);
    scl_m = 1'b1; waitq(1);
    ack = ~sda_line; waitq(1);
    scl_m = 1'b0; waitq(1);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; waitq(1);
      scl_m = 1'b1; waitq(1);
      b[i] = sda_line; waitq(1);
      scl_m = 1'b0; waitq(1);
    end
    sda_m = ~mack; waitq(1);
    scl_m = 1'b1; waitq(2);
    scl_m = 1'b0; waitq(1);
    sda_m = 1'b1;
  endtask

  task automatic set_ptr(input logic [7:0] r, input string req);
    logic a;
    bus_start();
    send_byte(8'h88, a); chk({req, " address write ack"}, a, 1);
    send_byte(r, a);     chk({req, " pointer ack"}, a, 1);
  endtask

  task automatic read_seq(input logic [7:0] r, input int n, input string req);
    logic a;
    logic [7:0] d;
    set_ptr(r, req);
    bus_start();
    send_byte(8'h89, a); chk({req, " address read ack"}, a, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, d);
      chk({req, " read data"}, d, expv[(int'(r) + k) % NREG]);
    end
    bus_stop();
  endtask

  task automatic t_reset();
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 reg_we", reg_we, 0);
    chk("R1 reg_raddr", reg_raddr, 0);
  endtask

  task automatic t_no_start();
    logic a;
    int w0 = we_cnt, o0 = oe_cnt;
    scl_m = 1'b0; waitq(1);
    send_byte(8'h88, a); chk("R3 no ack without START", a, 0);
    send_byte(8'h03, a);
    send_byte(8'h77, a);
    scl_m = 1'b1; waitq(2);
    chk("R3 no write without START", we_cnt - w0, 0);
    chk("R3 SDA untouched without START", oe_cnt - o0, 0);
  endtask

  task automatic t_bad_addr();
    logic a;
    int w0 = we_cnt;
    bus_start();
    send_byte(8'h90, a); chk("R2 foreign address nack", a, 0);
    send_byte(8'h01, a); chk("R2 later byte nack", a, 0);
    send_byte(8'h3C, a); chk("R2 later data nack", a, 0);
    bus_stop();
    chk("R2 no write after foreign address", we_cnt - w0, 0);
  endtask

  task automatic t_byte_write();
    logic a;
    int w0 = we_cnt;
    set_ptr(8'h03, "R4");
    send_byte(8'h5A, a); chk("R4 data ack", a, 1);
    bus_stop();
    expv[3] = 8'h5A;
    chk("R4 single strobe", we_cnt - w0, 1);
    chk("R4 register updated", regs[3], 8'h5A);
  endtask

  task automatic t_burst_write_wrap();
    logic a;
    int w0 = we_cnt;
    set_ptr(8'h06, "R5");
    send_byte(8'h11, a); chk("R5 burst ack 0", a, 1);
    send_byte(8'h22, a); chk("R5 burst ack 1", a, 1);
    send_byte(8'h33, a); chk("R5 burst ack 2", a, 1);
    bus_stop();
    expv[6] = 8'h11; expv[7] = 8'h22; expv[0] = 8'h33;
    chk("R5 three strobes", we_cnt - w0, 3);
    chk("R5 last register", regs[7], 8'h22);
    chk("R5 wrapped to register 0", regs[0], 8'h33);
    chk("R5 last strobe address", reg_waddr, 0);
  endtask

  task automatic t_byte_read();
    read_seq(8'h03, 1, "R6");
    read_seq(8'h05, 1, "R6");
  endtask

  task automatic t_burst_read_wrap();
    read_seq(8'h06, 4, "R7");
    chk("R7 pointer after burst", reg_raddr, 2);
    chk("R7 SDA released after NACK", sda_oe, 0);
  endtask

  task automatic t_stop_midbyte();
    int w0 = we_cnt;
    set_ptr(8'h02, "R8");
    for (int i = 0; i < 4; i++) begin
      sda_m = 1'b1; waitq(1);
      scl_m = 1'b1; waitq(2);
      scl_m = 1'b0; waitq(1);
    end
    bus_stop();
    chk("R8 no write on truncated byte", we_cnt - w0, 0);
    read_seq(8'h02, 1, "R8");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREG; i++) expv[i] = 8'hA0 + 8'(i);
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    waitq(2);
    t_reset();
    t_no_start();
    t_bad_addr();
    t_byte_write();
    t_burst_write_wrap();
    t_byte_read();
    t_burst_read_wrap();
    t_stop_midbyte();
    chk("R9 SDA changes only with SCL low", bad_edge, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule